// File: doc/BRIEF.md
# Strap-Configured Audio Master Clock Generator

This block produces the bit clock and the left/right frame clock of an audio serial port from a single master clock, acting as the clock master. The two clock pins do two jobs. For a fixed window after reset they are inputs. Their levels, as set by board pull resistors, choose the speed mode (single or double) and the ratio family (base or one-and-a-half). When the window closes, the block latches that choice and starts driving both pins with the generated clocks.

A separate high/low select input picks the smaller or the doubled master-clock-per-frame ratio within the chosen mode and family. A change on this input is applied only at the next frame boundary. The bit clock always completes 64 periods per frame. The latched mode and family are presented as status outputs.

Top module: `audclk_master_gen`

## Requirements
- R1: Both output enables stay low while reset is asserted and for exactly 1024 master-clock cycles after reset is released. Both pad outputs are low during that time. Both enables go high on the next cycle and stay high until reset.
- R2: The frame pin level that is synchronized and latched in the last window cycle sets `stat_dbl_o`: 0 (low strap) means single speed and 1 (high strap) means double speed. Only the level at the end of the window counts.
- R3: The bit pin level latched in the last window cycle sets `stat_wide_o`: 0 (low strap) means the base family and 1 (high strap) means the one-and-a-half family.
- R4: The number of master clocks per frame is 256 or 512 for single speed base, 384 or 768 for single speed wide, 128 or 256 for double speed base, and 192 or 384 for double speed wide. The second value of each pair applies when `hi_rate_i` is 1.
- R5: Each half of a frame holds exactly 32 rising edges of the bit clock, so there are 64 bit-clock periods per frame.
- R6: The bit-clock divisor is d = (clocks per frame)/64. In each bit period the bit clock is low for d - floor(d/2) cycles and then high for floor(d/2) cycles, so d = 3 gives 1 cycle high and 2 cycles low.
- R7: The frame clock is low for exactly 32·d cycles and then high for exactly 32·d cycles.
- R8: On the first cycle after the window, both generated clocks are low. A frame begins with the left (low) half.
- R9: The frame clock changes only in a cycle where the bit clock goes from high to low.
- R10: A change of `hi_rate_i` while the clocks run leaves the current frame at the old ratio. The new ratio starts with the next frame.
- R11: Both status outputs are 0 during reset. Strap pin changes after the window do not affect the status outputs, and the status outputs stay fixed until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_rate_i | input | 1 | 1 selects the doubled ratio within the mode and family |
| frm_pad_i | input | 1 | Frame pin input level, used as the speed strap |
| frm_pad_o | output | 1 | Frame clock driven onto the pin |
| frm_pad_oe | output | 1 | Frame pin output enable |
| bit_pad_i | input | 1 | Bit pin input level, used as the family strap |
| bit_pad_o | output | 1 | Bit clock driven onto the pin |
| bit_pad_oe | output | 1 | Bit pin output enable |
| stat_dbl_o | output | 1 | Latched speed mode, 1 for double speed |
| stat_wide_o | output | 1 | Latched ratio family, 1 for one-and-a-half family |

## Verification
The enables and status are due on the 1024th rising edge after reset is released. The bench therefore samples the pins on the falling edge just before that rising edge and on the falling edge just after it. The clock waveforms are checked by a scoreboard that is one half-frame long. The driver queues the expected ratio for each half. The monitor measures each half on falling edges and compares it when the frame clock toggles, so every result is judged only once it is complete. The select change is applied at the start of a frame's first half. That is hundreds of cycles ahead of the boundary, well beyond the two-cycle synchronizer, so the expected switch-over falls on a known half.

// File: rtl/audclk_pkg.sv
// Shared types and the divisor rule for the strap-configured audio clock generator.
// Assumes the bit clock runs 64 periods per frame, so divisors stay below 16.
package audclk_pkg;

    localparam int DIV_W = 4;

    typedef struct packed {
        logic dbl;   // 1: double-speed mode
        logic wide;  // 1: one-and-a-half ratio family
    } strap_cfg_t;

    // Master clocks per bit-clock period for a mode, family and high/low pick.
    function automatic logic [DIV_W-1:0] bit_div(input strap_cfg_t cfg, input logic hi);
        logic [DIV_W-1:0] d;
        d = cfg.wide ? DIV_W'(3) : DIV_W'(2);
        if (!cfg.dbl) d = d << 1;
        if (hi)       d = d << 1;
        return d;
    endfunction

endpackage

// File: rtl/audclk_sync.sv
// Multi-flop synchronizer for asynchronous level inputs.
// Assumes the inputs are quasi-static levels; a parameter selects the chain depth.
module audclk_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES*W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) chain_q <= '0;
                else          chain_q <= d_i;
            end
        end else begin : g_many
            // Shift the level through the whole chain.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) chain_q <= '0;
                else          chain_q <= {chain_q[(STAGES-1)*W-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES*W-1 -: W];

endmodule

// File: rtl/audclk_strap.sv
// Power-up strap window: counts WIN_CYCLES clocks after reset, synchronizes the
// two strap pins and latches them on the last window cycle.
// Assumes the board holds the strap levels stable near the end of the window.
module audclk_strap
    import audclk_pkg::*;
#(
    parameter int WIN_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       frm_strap_i,
    input  logic       bit_strap_i,
    output strap_cfg_t cfg_eff_o,
    output strap_cfg_t cfg_latched_o,
    output logic       done_o
);

    localparam int WIN_W = $clog2(WIN_CYCLES + 1);

    logic [1:0]       strap_sync;
    strap_cfg_t       strap_now;
    logic [WIN_W-1:0] win_cnt_q;
    logic             done_q;
    strap_cfg_t       latched_q;
    logic             last_cycle;

    audclk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_strap_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     ({frm_strap_i, bit_strap_i}),
        .q_o     (strap_sync)
    );

    assign strap_now  = '{dbl: strap_sync[1], wide: strap_sync[0]};
    assign last_cycle = !done_q && (win_cnt_q == WIN_W'(WIN_CYCLES - 1));

    // Window counter, frozen once the window has closed.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)    win_cnt_q <= '0;
        else if (!done_q) win_cnt_q <= win_cnt_q + WIN_W'(1);
    end

    // Window-closed flag, set on the last window cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)       done_q <= 1'b0;
        else if (last_cycle) done_q <= 1'b1;
    end

    // Strap latch, loaded once per reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)       latched_q <= '0;
        else if (last_cycle) latched_q <= strap_now;
    end

    assign cfg_eff_o     = done_q ? latched_q : strap_now;
    assign cfg_latched_o = latched_q;
    assign done_o        = done_q;

endmodule

// File: rtl/audclk_divgen.sv
// Bit- and frame-clock divider. The bit clock is low for ceil(d/2) and high for
// floor(d/2) master clocks; the frame clock toggles every BITS_PER_FRAME/2 bits,
// always where the bit clock falls. The divisor reloads only at frame ends.
// Assumes run_i rises once per reset and cfg_i/hi_i are synchronous.
module audclk_divgen
    import audclk_pkg::*;
#(
    parameter int BITS_PER_FRAME = 64
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       run_i,
    input  strap_cfg_t cfg_i,
    input  logic       hi_i,
    output logic       bclk_o,
    output logic       fclk_o
);

    localparam int BIT_W = $clog2(BITS_PER_FRAME);
    localparam int HALF  = BITS_PER_FRAME / 2;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] ph_q;
    logic [BIT_W-1:0] bit_q;
    logic [DIV_W-1:0] next_div;
    logic [DIV_W-1:0] hi_thr;
    logic             ph_last;
    logic             frame_last;

    assign next_div   = bit_div(cfg_i, hi_i);
    assign hi_thr     = div_q - (div_q >> 1);
    assign ph_last    = (ph_q == div_q - DIV_W'(1));
    assign frame_last = ph_last && (bit_q == BIT_W'(BITS_PER_FRAME - 1));

    // Active divisor: tracks the config before running, then reloads per frame.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                div_q <= DIV_W'(2);
        else if (!run_i || frame_last) div_q <= next_div;
    end

    // Phase within one bit-clock period.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i) ph_q <= '0;
        else if (ph_last)       ph_q <= '0;
        else                    ph_q <= ph_q + DIV_W'(1);
    end

    // Bit index within the frame.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i) bit_q <= '0;
        else if (frame_last)    bit_q <= '0;
        else if (ph_last)       bit_q <= bit_q + BIT_W'(1);
    end

    assign bclk_o = run_i && (ph_q >= hi_thr);
    assign fclk_o = run_i && (bit_q >= BIT_W'(HALF));

endmodule

// File: rtl/audclk_master_gen.sv
// Strap-configured audio master clock generator (top). Samples the frame and
// bit pins as straps during the power-up window, then drives them as clocks.
// Assumes an external pad cell that uses the enables to choose the pin direction.
module audclk_master_gen
    import audclk_pkg::*;
#(
    parameter int WIN_CYCLES     = 1024,
    parameter int BITS_PER_FRAME = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic mclk_i,
    input  logic rst_n,
    input  logic hi_rate_i,
    input  logic frm_pad_i,
    output logic frm_pad_o,
    output logic frm_pad_oe,
    input  logic bit_pad_i,
    output logic bit_pad_o,
    output logic bit_pad_oe,
    output logic stat_dbl_o,
    output logic stat_wide_o
);

    strap_cfg_t cfg_eff;
    strap_cfg_t cfg_latched;
    logic       win_done;
    logic       hi_sync;
    logic       bclk;
    logic       fclk;

    audclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_hi_sync (
        .clk_i   (mclk_i),
        .rst_n_i (rst_n),
        .d_i     (hi_rate_i),
        .q_o     (hi_sync)
    );

    audclk_strap #(.WIN_CYCLES(WIN_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_strap (
        .clk_i         (mclk_i),
        .rst_n_i       (rst_n),
        .frm_strap_i   (frm_pad_i),
        .bit_strap_i   (bit_pad_i),
        .cfg_eff_o     (cfg_eff),
        .cfg_latched_o (cfg_latched),
        .done_o        (win_done)
    );

    audclk_divgen #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_div (
        .clk_i   (mclk_i),
        .rst_n_i (rst_n),
        .run_i   (win_done),
        .cfg_i   (cfg_eff),
        .hi_i    (hi_sync),
        .bclk_o  (bclk),
        .fclk_o  (fclk)
    );

    assign frm_pad_o   = fclk;
    assign bit_pad_o   = bclk;
    assign frm_pad_oe  = win_done;
    assign bit_pad_oe  = win_done;
    assign stat_dbl_o  = cfg_latched.dbl;
    assign stat_wide_o = cfg_latched.wide;

endmodule

// File: rtl/audclk_master_gen_chk.sv
// Protocol checker for audclk_master_gen, attached with bind.
// Assumes the default 64-bit frame, so the longest bit-clock high time is 6.
module audclk_master_gen_chk #(
    parameter int MAX_HIGH = 6
) (
    input logic mclk_i,
    input logic rst_n,
    input logic frm_pad_o,
    input logic frm_pad_oe,
    input logic bit_pad_o,
    input logic bit_pad_oe,
    input logic stat_dbl_o,
    input logic stat_wide_o
);

    logic [7:0] hi_run_q;

    // Consecutive high cycles of the bit clock.
    always_ff @(posedge mclk_i) begin
        if (!rst_n || !bit_pad_o) hi_run_q <= '0;
        else if (hi_run_q != 8'hff) hi_run_q <= hi_run_q + 8'd1;
    end

    assert_oe_sticky_R1: assert property (@(posedge mclk_i) disable iff (!rst_n)
        $past(frm_pad_oe) |-> (frm_pad_oe && bit_pad_oe));

    assert_quiet_in_window_R1: assert property (@(posedge mclk_i) disable iff (!rst_n)
        !frm_pad_oe |-> (!frm_pad_o && !bit_pad_o));

    assert_start_low_R8: assert property (@(posedge mclk_i) disable iff (!rst_n)
        $rose(frm_pad_oe) |-> (!frm_pad_o && !bit_pad_o));

    assert_frame_on_fall_R9: assert property (@(posedge mclk_i) disable iff (!rst_n)
        (frm_pad_oe && $past(frm_pad_oe) && (frm_pad_o != $past(frm_pad_o)))
            |-> ($past(bit_pad_o) && !bit_pad_o));

    assert_status_fixed_R11: assert property (@(posedge mclk_i) disable iff (!rst_n)
        (frm_pad_oe && $past(frm_pad_oe)) |-> ($stable(stat_dbl_o) && $stable(stat_wide_o)));

    assert_high_bound_R6: assert property (@(posedge mclk_i) disable iff (!rst_n)
        hi_run_q <= 8'(MAX_HIGH));

endmodule

bind audclk_master_gen audclk_master_gen_chk u_chk (
    .mclk_i      (mclk_i),
    .rst_n       (rst_n),
    .frm_pad_o   (frm_pad_o),
    .frm_pad_oe  (frm_pad_oe),
    .bit_pad_o   (bit_pad_o),
    .bit_pad_oe  (bit_pad_oe),
    .stat_dbl_o  (stat_dbl_o),
    .stat_wide_o (stat_wide_o)
);

// File: tb/tb_audclk_master_gen.sv
// Scoreboard bench: the driver queues one expected ratio per half frame, the
// monitor measures each half on falling edges and compares when it completes.
module tb_audclk_master_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 1024;
    localparam int BITS       = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_rate = 1'b0;
    logic frm_pi = 1'b0;
    logic bit_pi = 1'b0;
    logic frm_pad_o, frm_pad_oe, bit_pad_o, bit_pad_oe, stat_dbl_o, stat_wide_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audclk_master_gen dut (
        .mclk_i      (clk),
        .rst_n       (rst_n),
        .hi_rate_i   (hi_rate),
        .frm_pad_i   (frm_pi),
        .frm_pad_o   (frm_pad_o),
        .frm_pad_oe  (frm_pad_oe),
        .bit_pad_i   (bit_pi),
        .bit_pad_o   (bit_pad_o),
        .bit_pad_oe  (bit_pad_oe),
        .stat_dbl_o  (stat_dbl_o),
        .stat_wide_o (stat_wide_o)
    );

    typedef struct {
        int    ratio;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input bit dbl, input bit wide, input bit hi);
        int r;
        r = dbl ? 128 : 256;
        if (wide) r = r * 3 / 2;
        if (hi)   r = r * 2;
        return r;
    endfunction

    // Monitor state
    bit prev_oe = 1'b0;
    bit prev_b, prev_f;
    int half_len, rises, run_len, run_bad, bad_val, bad_exp;

    always @(negedge clk) begin
        if (!rst_n || !frm_pad_oe) begin
            prev_oe = 1'b0;
        end else if (!prev_oe) begin
            check(!frm_pad_o && !bit_pad_o, "R8 clocks low on first run cycle",
                  {frm_pad_o, bit_pad_o}, 0);
            prev_oe  = 1'b1;
            prev_b   = bit_pad_o;
            prev_f   = frm_pad_o;
            half_len = 1;
            rises    = 0;
            run_len  = 1;
            run_bad  = 0;
        end else begin
            if (bit_pad_o != prev_b) begin
                if (sb_q.size() > 0) begin
                    int d, e;
                    d = sb_q[0].ratio / BITS;
                    e = prev_b ? d / 2 : d - d / 2;
                    if (run_len != e) begin
                        if (run_bad == 0) begin
                            bad_val = run_len;
                            bad_exp = e;
                        end
                        run_bad++;
                    end
                end
                run_len = 1;
                if (bit_pad_o) rises++;
            end else begin
                run_len++;
            end
            if (frm_pad_o != prev_f) begin
                check(prev_b && !bit_pad_o, "R9 frame edge where bit clock falls",
                      {prev_b, bit_pad_o}, 2);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected half frame", half_len, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(half_len == e.ratio / 2, {"R4 R7 half length ", e.tag},
                          half_len, e.ratio / 2);
                    check(rises == BITS / 2, "R5 bit rises per half", rises, BITS / 2);
                    check(run_bad == 0, "R6 bit clock high/low run", bad_val, bad_exp);
                end
                half_len = 1;
                rises    = 0;
                run_bad  = 0;
            end else begin
                half_len++;
            end
            prev_b = bit_pad_o;
            prev_f = frm_pad_o;
        end
    end

    // Driver: one reset, window and run for a configuration.
    task automatic run_cfg(input bit dbl, input bit wide, input bit hi, input bit toggle,
                           input bit flip_win, input bit flip_after);
        int r0, r1, rem;
        @(negedge clk);
        rst_n   = 1'b0;
        frm_pi  = flip_win ? ~dbl : dbl;
        bit_pi  = flip_win ? ~wide : wide;
        hi_rate = hi;
        r0 = ratio_of(dbl, wide, hi);
        r1 = ratio_of(dbl, wide, !hi);
        for (int i = 0; i < 4; i++) sb_q.push_back('{r0, toggle ? "R10 old ratio" : "steady"});
        if (toggle) for (int i = 0; i < 4; i++) sb_q.push_back('{r1, "R10 new ratio"});
        repeat (3) @(negedge clk);
        check(!frm_pad_oe && !bit_pad_oe, "R1 enables low in reset", {frm_pad_oe, bit_pad_oe}, 0);
        check(!stat_dbl_o && !stat_wide_o, "R11 status cleared in reset",
              {stat_dbl_o, stat_wide_o}, 0);
        rst_n = 1'b1;
        rem = WIN - 1;
        if (flip_win) begin
            repeat (8) @(negedge clk);
            frm_pi = dbl;
            bit_pi = wide;
            rem = rem - 8;
        end
        repeat (rem) @(negedge clk);
        check(!frm_pad_oe && !bit_pad_oe && !frm_pad_o && !bit_pad_o,
              "R1 pins idle on last window cycle",
              {frm_pad_oe, bit_pad_oe, frm_pad_o, bit_pad_o}, 0);
        @(negedge clk);
        check(frm_pad_oe && bit_pad_oe, "R1 enables high after window",
              {frm_pad_oe, bit_pad_oe}, 3);
        check(stat_dbl_o == dbl, "R2 speed strap", stat_dbl_o, dbl);
        check(stat_wide_o == wide, "R3 family strap", stat_wide_o, wide);
        if (flip_after) begin
            frm_pi = ~dbl;
            bit_pi = ~wide;
        end
        if (toggle) begin
            while (sb_q.size() > 6) @(negedge clk);
            hi_rate = !hi;
        end
        while (sb_q.size() != 0) @(negedge clk);
        if (flip_after) begin
            check(stat_dbl_o == dbl && stat_wide_o == wide, "R11 status ignores late straps",
                  {stat_dbl_o, stat_wide_o}, {dbl, wide});
        end
        check(frm_pad_oe && bit_pad_oe, "R1 enables stay high", {frm_pad_oe, bit_pad_oe}, 3);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        run_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // 256
        run_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // 512
        run_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // 384 then 768
        run_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // 128, straps settle late in window
        run_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // 256
        run_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // 384 then 192
        run_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // 192, straps flipped after window
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule